// File: doc/BRIEF.md
# Neuron Processing Engine

This block is one processing engine of a small fixed-point neural accelerator. A static schedule assigns it a list of neurons. The engine works through that list in order and then starts again from the first neuron. For each neuron it takes a configured number of values from its input queue. It multiplies each value by the next weight from a circular weight store and sums the products in a wide accumulator. The sum is clamped to a bounded range and turned into an index into a sigmoid lookup table. The table entry is written to the next slot of a small output register file, which the shared bus reads through a combinational read port.

The engine is set up through one configuration port. That port loads the weights, the input count of each neuron and the activation table. A commit command then sets the weight length and the neuron count and restarts the sequencing. Each value the bus pushes into the input queue is consumed exactly once, in arrival order. The weight pointer runs around the loaded weights without stopping, so a schedule whose total input count equals the weight length reuses the same weights on every invocation.

Top module: `npe_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `res_strobe` is 0 and every output register reads 0.
- R2: A neuron's result is `LUT[idx]`. `idx` is computed from S, the sum over its inputs of `(x*w) >>> 16`, where x and w are signed Q16.16 and the arithmetic shift floors.
- R3: S is clamped to the range [-524288, 524287], which is -8.0 to just under +8.0. Then `idx = (S_clamped + 524288) >> 13`. Any sum at or above +8.0 therefore uses entry 127, and any sum at or below -8.0 uses entry 0.
- R4: A neuron finishes after exactly its configured count of multiply-accumulates. Its result goes to the next output slot, with slots 0..7 used in order and wrapping from 7 to 0. In the cycle after the write, `res_strobe` is 1 and `res_slot` holds that slot.
- R5: The weight read pointer advances by one on each multiply-accumulate and wraps to 0 after entry length-1. This holds even in the middle of a neuron or of an invocation.
- R6: When the input queue is empty and the current neuron still needs inputs, the engine waits. The partial sum is kept, and gaps between inputs do not change any result.
- R7: The input queue holds 8 entries. `in_ready` is 0 while 8 are held, and a push made while it is 0 is dropped.
- R8: Until the first commit with a nonzero neuron count, no input is consumed and no result is produced.
- R9: After the last configured neuron, the engine continues with neuron 0.
- R10: Configuration encoding uses `cfg_sel`. Code 0 writes weight `cfg_addr` with `cfg_data`. Code 1 writes the input count of neuron `cfg_addr[2:0]` from `cfg_data[9:0]`, with valid counts 1..1023. Code 2 writes table entry `cfg_addr[6:0]`. Code 3 commits: the weight length comes from `cfg_data[9:0]` (1..512) and the neuron count from `cfg_data[19:16]` (1..8). A commit resets the weight pointer, the neuron index, the output slot and the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Bus offers a value to the input queue |
| in_data | input | 32 | Q16.16 input value |
| in_ready | output | 1 | Input queue has room |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target code |
| cfg_addr | input | 9 | Configuration address |
| cfg_data | input | 32 | Configuration data |
| rd_addr | input | 3 | Output register file read address |
| rd_data | output | 32 | Output register file read data |
| res_strobe | output | 1 | A result was written in the previous cycle |
| res_slot | output | 3 | Slot of that result |

## Verification
The first invocation is queued in full before any commit. This shows whether the engine holds off until configured and whether a push into a full queue is really dropped, because a stray extra value would shift every later sum. A second invocation trickles inputs in with idle gaps, including a long pause partway through a neuron; this separates a correct stall from one that loses or reuses a partial sum. Large positive and negative sums, together with sums of exactly +8.0 and 0, test the clamp and the index boundaries. A final reconfiguration uses a weight length shorter than the neuron's input count, so the pointer wrap falls inside a neuron and moves from one invocation to the next.

// File: rtl/npe_pkg.sv
package npe_pkg;

    localparam int NPE_DATA_W      = 32;
    localparam int NPE_FRAC        = 16;
    localparam int NPE_ACC_W       = 48;
    localparam int NPE_WT_DEPTH    = 512;
    localparam int NPE_INQ_DEPTH   = 8;
    localparam int NPE_ORF_DEPTH   = 8;
    localparam int NPE_LUT_DEPTH   = 128;
    localparam int NPE_MAX_NEURONS = 8;
    localparam int NPE_CNT_W       = 10;
    localparam int NPE_RANGE       = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_ACT  = 2'd2
    } npe_state_e;

    typedef enum logic [1:0] {
        CFG_WEIGHT = 2'd0,
        CFG_NCOUNT = 2'd1,
        CFG_LUT    = 2'd2,
        CFG_COMMIT = 2'd3
    } npe_cfg_e;

endpackage

// File: rtl/npe_in_queue.sv
module npe_in_queue #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } q_state_t;

    q_state_t q_q, q_d;
    logic [W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign full    = (q_q.cnt == CW'(DEPTH));
    assign empty   = (q_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem_q[q_q.rp];

    always_comb begin
        q_d = q_q;
        if (push_ok) begin
            q_d.wp = (q_q.wp == PW'(DEPTH - 1)) ? '0 : q_q.wp + PW'(1);
        end
        if (pop_ok) begin
            q_d.rp = (q_q.rp == PW'(DEPTH - 1)) ? '0 : q_q.rp + PW'(1);
        end
        case ({push_ok, pop_ok})
            2'b10:   q_d.cnt = q_q.cnt + CW'(1);
            2'b01:   q_d.cnt = q_q.cnt - CW'(1);
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[q_q.wp] <= din;
    end

    // R7: occupancy never exceeds the queue depth
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= CW'(DEPTH));

    // R7: a full queue with no pop stays full, so a push is dropped
    a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full && $stable(q_q.wp));

endmodule

// File: rtl/npe_weight_ring.sv
module npe_weight_ring #(
    parameter int W     = 32,
    parameter int DEPTH = 512
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(DEPTH)-1:0]     wr_addr,
    input  logic [W-1:0]                 wr_data,
    input  logic                         load_len,
    input  logic [$clog2(DEPTH+1)-1:0]   len_in,
    input  logic                         advance,
    output logic [W-1:0]                 rd_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [LW-1:0] len;
    } ring_t;

    ring_t r_q, r_d;
    logic [W-1:0] mem_q [DEPTH];
    logic at_last;

    assign at_last = ({1'b0, r_q.ptr} == (r_q.len - LW'(1)));
    assign rd_data = mem_q[r_q.ptr];

    always_comb begin
        r_d = r_q;
        if (load_len) begin
            r_d.len = len_in;
            r_d.ptr = '0;
        end else if (advance) begin
            r_d.ptr = at_last ? '0 : r_q.ptr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    // R5: consuming the last loaded weight returns the pointer to entry 0
    a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load_len && r_q.len != '0 && at_last) |=> r_q.ptr == '0);

    // R5: pointer stays inside the loaded length
    a_r5_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.len != '0) |-> ({1'b0, r_q.ptr} < r_q.len));

endmodule

// File: rtl/npe_sigmoid_index.sv
module npe_sigmoid_index #(
    parameter int ACC_W     = 48,
    parameter int FRAC      = 16,
    parameter int RANGE     = 8,
    parameter int LUT_DEPTH = 128
) (
    input  logic signed [ACC_W-1:0]          acc,
    output logic [$clog2(LUT_DEPTH)-1:0]     idx
);
    localparam int     IDX_W  = $clog2(LUT_DEPTH);
    localparam int     SPAN_W = $clog2(2 * RANGE) + FRAC;
    localparam longint HI_L   = (longint'(RANGE) <<< FRAC) - 1;
    localparam longint LO_L   = -(longint'(RANGE) <<< FRAC);
    localparam logic signed [ACC_W-1:0] LIM_HI = ACC_W'(HI_L);
    localparam logic signed [ACC_W-1:0] LIM_LO = ACC_W'(LO_L);

    logic signed [ACC_W-1:0] clamped;
    logic [SPAN_W-1:0]       offset;

    always_comb begin
        if (acc > LIM_HI)      clamped = LIM_HI;
        else if (acc < LIM_LO) clamped = LIM_LO;
        else                   clamped = acc;
        offset = SPAN_W'(clamped - LIM_LO);
        idx    = IDX_W'(offset >> (SPAN_W - IDX_W));
    end

endmodule

// File: rtl/npe_engine.sv
module npe_engine
    import npe_pkg::*;
#(
    parameter int DATA_W      = NPE_DATA_W,
    parameter int FRAC        = NPE_FRAC,
    parameter int ACC_W       = NPE_ACC_W,
    parameter int WT_DEPTH    = NPE_WT_DEPTH,
    parameter int INQ_DEPTH   = NPE_INQ_DEPTH,
    parameter int ORF_DEPTH   = NPE_ORF_DEPTH,
    parameter int LUT_DEPTH   = NPE_LUT_DEPTH,
    parameter int MAX_NEURONS = NPE_MAX_NEURONS,
    parameter int CNT_W       = NPE_CNT_W,
    parameter int RANGE       = NPE_RANGE
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [DATA_W-1:0]             in_data,
    output logic                          in_ready,
    input  logic                          cfg_we,
    input  logic [1:0]                    cfg_sel,
    input  logic [$clog2(WT_DEPTH)-1:0]   cfg_addr,
    input  logic [31:0]                   cfg_data,
    input  logic [$clog2(ORF_DEPTH)-1:0]  rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          res_strobe,
    output logic [$clog2(ORF_DEPTH)-1:0]  res_slot
);
    localparam int AW      = $clog2(WT_DEPTH);
    localparam int LEN_W   = $clog2(WT_DEPTH + 1);
    localparam int SLOT_W  = $clog2(ORF_DEPTH);
    localparam int NIDX_W  = $clog2(MAX_NEURONS);
    localparam int NN_W    = $clog2(MAX_NEURONS + 1);
    localparam int LIDX_W  = $clog2(LUT_DEPTH);
    localparam int PROD_W  = 2 * DATA_W;
    localparam int NN_LSB  = 16;
    localparam longint SAT_L = (longint'(RANGE) <<< FRAC);

    typedef struct packed {
        npe_state_e              st;
        logic signed [ACC_W-1:0] acc;
        logic [CNT_W-1:0]        mac;
        logic [NIDX_W-1:0]       nidx;
        logic [SLOT_W-1:0]       slot;
        logic                    strobe;
        logic [SLOT_W-1:0]       last;
        logic [NN_W-1:0]         nn;
    } seq_t;

    seq_t s_q, s_d;

    logic [CNT_W-1:0]  ncount_q [MAX_NEURONS];
    logic [DATA_W-1:0] lut_q    [LUT_DEPTH];
    logic [DATA_W-1:0] orf_q    [ORF_DEPTH];

    logic                    cfg_weight, cfg_ncount, cfg_lut, cfg_commit;
    logic                    q_full, q_empty, pop;
    logic [DATA_W-1:0]       q_dout, w_rd;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0] term;
    logic [CNT_W-1:0]        cur_cnt;
    logic [LIDX_W-1:0]       lut_idx;
    logic                    orf_we;
    logic [DATA_W-1:0]       act_val;
    logic                    unused_bits;

    assign cfg_weight = cfg_we && (cfg_sel == CFG_WEIGHT);
    assign cfg_ncount = cfg_we && (cfg_sel == CFG_NCOUNT);
    assign cfg_lut    = cfg_we && (cfg_sel == CFG_LUT);
    assign cfg_commit = cfg_we && (cfg_sel == CFG_COMMIT);

    assign unused_bits = ^{cfg_data[31:NN_LSB+NN_W], cfg_data[NN_LSB-1:LEN_W], prod[FRAC-1:0]};

    // ---- input queue ------------------------------------------------------
    npe_in_queue #(.W(DATA_W), .DEPTH(INQ_DEPTH)) u_inq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_valid),
        .din   (in_data),
        .pop   (pop),
        .dout  (q_dout),
        .full  (q_full),
        .empty (q_empty)
    );
    assign in_ready = !q_full;

    // ---- circular weight store --------------------------------------------
    npe_weight_ring #(.W(DATA_W), .DEPTH(WT_DEPTH)) u_wring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_weight),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_data[DATA_W-1:0]),
        .load_len (cfg_commit),
        .len_in   (cfg_data[LEN_W-1:0]),
        .advance  (pop),
        .rd_data  (w_rd)
    );

    // ---- activation index -------------------------------------------------
    npe_sigmoid_index #(
        .ACC_W(ACC_W), .FRAC(FRAC), .RANGE(RANGE), .LUT_DEPTH(LUT_DEPTH)
    ) u_sidx (
        .acc (s_q.acc),
        .idx (lut_idx)
    );

    // ---- datapath and sequencer -------------------------------------------
    always_comb begin
        pop     = (s_q.st == ST_ACC) && !q_empty && !cfg_commit;
        prod    = $signed(q_dout) * $signed(w_rd);
        term    = prod[FRAC +: ACC_W];
        cur_cnt = ncount_q[s_q.nidx];
        act_val = lut_q[lut_idx];
        orf_we  = 1'b0;

        s_d        = s_q;
        s_d.strobe = 1'b0;

        if (cfg_commit) begin
            s_d.nn   = cfg_data[NN_LSB +: NN_W];
            s_d.st   = (cfg_data[NN_LSB +: NN_W] != '0) ? ST_ACC : ST_IDLE;
            s_d.acc  = '0;
            s_d.mac  = '0;
            s_d.nidx = '0;
            s_d.slot = '0;
        end else begin
            case (s_q.st)
                ST_ACC: begin
                    if (pop) begin
                        s_d.acc = s_q.acc + term;
                        s_d.mac = s_q.mac + CNT_W'(1);
                        if ((s_q.mac + CNT_W'(1)) >= cur_cnt) s_d.st = ST_ACT;
                    end
                end
                ST_ACT: begin
                    orf_we     = 1'b1;
                    s_d.acc    = '0;
                    s_d.mac    = '0;
                    s_d.nidx   = ((NN_W'(s_q.nidx) + NN_W'(1)) >= s_q.nn) ? '0
                                 : s_q.nidx + NIDX_W'(1);
                    s_d.slot   = (s_q.slot == SLOT_W'(ORF_DEPTH - 1)) ? '0
                                 : s_q.slot + SLOT_W'(1);
                    s_d.last   = s_q.slot;
                    s_d.strobe = 1'b1;
                    s_d.st     = ST_ACC;
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // ---- configuration tables ---------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_NEURONS; i++) ncount_q[i] <= '0;
        end else if (cfg_ncount) begin
            ncount_q[cfg_addr[NIDX_W-1:0]] <= cfg_data[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (cfg_lut) lut_q[cfg_addr[LIDX_W-1:0]] <= cfg_data[DATA_W-1:0];
    end

    // ---- output register file ---------------------------------------------
    for (genvar g = 0; g < ORF_DEPTH; g++) begin : g_orf
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   orf_q[g] <= '0;
            else if (orf_we && s_q.slot == SLOT_W'(g))    orf_q[g] <= act_val;
        end
    end

    assign rd_data    = orf_q[rd_addr];
    assign res_strobe = s_q.strobe;
    assign res_slot   = s_q.last;

    // ---- assertions -------------------------------------------------------
    // R4: a result strobe only ever follows an activation cycle
    a_r4_strobe_after_act: assert property (@(posedge clk) disable iff (!rst_n)
        res_strobe |-> $past(s_q.st) == ST_ACT);

    // R6: with an empty queue the partial sum and count are held
    a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_ACC && q_empty && !cfg_commit) |=> ($stable(s_q.acc) && $stable(s_q.mac)));

    // R3: sums at or above the upper bound select the top table entry
    a_r3_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_ACT && s_q.acc >= ACC_W'(SAT_L)) |-> lut_idx == LIDX_W'(LUT_DEPTH - 1));

    // R3: sums at or below the lower bound select entry 0
    a_r3_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_ACT && s_q.acc <= -ACC_W'(SAT_L)) |-> lut_idx == '0);

    // R8: nothing is consumed while no neuron list is committed
    a_r8_idle_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && !q_empty && !cfg_commit) |=> $stable(s_q.acc) && !res_strobe);

endmodule

// File: tb/sim_npe_engine.sv
module sim_npe_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [8:0]  cfg_addr = '0;
    logic [31:0] cfg_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        res_strobe;
    logic [2:0]  res_slot;

    always #2ns clk = ~clk;

    npe_engine u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .res_strobe(res_strobe), .res_slot(res_slot)
    );

    int checks = 0;
    int failures = 0;
    int strobes = 0;
    bit done = 0;

    // model configuration and state
    int     lut_tab [128];
    int     wt [8];
    int     ncnt [8];
    int     wlen, nn;
    longint m_acc;
    int     m_wptr, m_n, m_cnt, m_slot;
    string  cur_req = "R2";

    int    exp_slot[$];
    int    exp_val[$];
    string exp_req[$];

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lut_of(input longint s);
        longint c;
        c = s;
        if (c > 524287) c = 524287;
        if (c < -524288) c = -524288;
        return lut_tab[int'((c + 524288) >>> 13)];
    endfunction

    task automatic model_reset();
        m_acc = 0; m_wptr = 0; m_n = 0; m_cnt = 0; m_slot = 0;
    endtask

    task automatic model_take(input int x);
        m_acc += (longint'(x) * longint'(wt[m_wptr])) >>> 16;
        m_wptr = (m_wptr + 1 == wlen) ? 0 : m_wptr + 1;
        m_cnt++;
        if (m_cnt == ncnt[m_n]) begin
            exp_slot.push_back(m_slot);
            exp_val.push_back(lut_of(m_acc));
            exp_req.push_back(cur_req);
            m_acc = 0; m_cnt = 0;
            m_n = (m_n + 1 == nn) ? 0 : m_n + 1;
            m_slot = (m_slot + 1) % 8;
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input int addr, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = 9'(addr); cfg_data = data;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // driver: pushes a value and predicts its effect when accepted
    task automatic push(input int x, output bit accepted);
        @(negedge clk);
        in_valid = 1'b1; in_data = x;
        accepted = in_ready;
        @(posedge clk); #1;
        in_valid = 1'b0;
        if (accepted) model_take(x);
    endtask

    task automatic push_n(input int x);
        bit a;
        push(x, a);
        check("R7", a == 1'b1, a, 1);
    endtask

    // monitor: compares each produced result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && res_strobe) begin
            strobes++;
            rd_addr = res_slot;
            #0.5ns;
            if (exp_val.size() == 0) begin
                check("R4", 1'b0, res_slot, -1);
            end else begin
                string r;
                int es, ev;
                es = exp_slot.pop_front();
                ev = exp_val.pop_front();
                r  = exp_req.pop_front();
                check(r, res_slot == 3'(es), res_slot, es);
                check(r, rd_data == ev, $signed(rd_data), ev);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit a;
        int s0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check("R1", in_ready == 1'b1, in_ready, 1);
        check("R1", res_strobe == 1'b0, res_strobe, 0);
        for (int i = 0; i < 8; i++) begin
            rd_addr = 3'(i);
            #0.5ns;
            check("R1", rd_data == 0, rd_data, 0);
        end

        // R10: configuration loads
        for (int i = 0; i < 128; i++) begin
            lut_tab[i] = i * 1000 + 7;
            cfg_write(2'd2, i, lut_tab[i]);
        end
        wt = '{32'h0001_0000, 32'h0000_8000, -32'sh0001_0000, 32'h0002_0000,
               32'h0000_4000, -32'sh0000_8000, 32'h0001_8000, 32'h0001_0000};
        for (int i = 0; i < 8; i++) cfg_write(2'd0, i, wt[i]);
        ncnt[0] = 3; ncnt[1] = 2; ncnt[2] = 3;
        for (int i = 0; i < 3; i++) cfg_write(2'd1, i, ncnt[i]);
        wlen = 8; nn = 3;
        model_reset();

        // R8/R7: queue fills before any commit
        cur_req = "R2";
        push_n(32'h0000_8000);  push_n(32'h0001_0000); push_n(-32'sh0000_4000);
        push_n(32'h0003_0000);  push_n(32'h0000_2000); push_n(-32'sh0002_0000);
        push_n(32'h0001_0000);  push_n(32'h0000_6000);
        @(negedge clk);
        check("R7", in_ready == 1'b0, in_ready, 0);
        push(32'h0070_0000, a);                 // dropped: queue is full
        check("R7", a == 1'b0, a, 0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check("R8", strobes == 0, strobes, 0);
        check("R8", in_ready == 1'b0, in_ready, 0);

        cfg_write(2'd3, 0, (nn << 16) | wlen);
        repeat (30) @(posedge clk);
        @(negedge clk);
        check("R7", in_ready == 1'b1, in_ready, 1);
        check("R4", strobes == 3, strobes, 3);

        // R6: trickled inputs with a long pause inside a neuron
        cur_req = "R6";
        push_n(32'h0001_0000);
        repeat (4) @(posedge clk);
        push_n(32'h0002_0000);
        s0 = strobes;
        repeat (15) @(posedge clk);
        @(negedge clk);
        check("R6", strobes == s0, strobes, s0);
        push_n(-32'sh0000_C000);
        for (int i = 0; i < 5; i++) begin
            push_n(32'h0000_3000 * (i + 1));
            repeat (3) @(posedge clk);
        end
        repeat (20) @(posedge clk);

        // R3: saturation and boundaries, slots wrap (R4) and list wraps (R9)
        cur_req = "R3";
        push_n(32'h0064_0000); push_n(0); push_n(0);        // +100 -> entry 127
        push_n(-32'sh0032_0000); push_n(0);                  // -100 -> entry 0
        push_n(32'h0010_0000); push_n(0); push_n(0);         // -8 exactly -> entry 0
        push_n(32'h0008_0000); push_n(0); push_n(0);         // +8 exactly -> entry 127
        cur_req = "R9";
        push_n(0); push_n(0);                                // 0 -> entry 64
        push_n(32'h0001_0000); push_n(32'h0000_8000); push_n(32'h0002_0000);
        repeat (30) @(posedge clk);
        @(negedge clk);
        check("R4", exp_val.size() == 0, exp_val.size(), 0);

        // R5/R10: shorter weight ring, one long neuron, wrap inside neuron
        cfg_write(2'd1, 0, 8);
        ncnt[0] = 8; wlen = 5; nn = 1;
        cfg_write(2'd3, 0, (nn << 16) | wlen);
        model_reset();
        cur_req = "R5";
        for (int k = 0; k < 16; k++) push_n(32'h0000_4000 * (k % 5 + 1) - 32'h0000_8000);
        repeat (30) @(posedge clk);
        @(negedge clk);
        check("R5", exp_val.size() == 0, exp_val.size(), 0);
        check("R10", strobes == 3 + 3 + 6 + 2, strobes, 14);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule